// File: doc/BRIEF.md
# Memory Mode Register Load Sequencer

This block sits in a low-power DDR SDRAM controller and owns the mode-register programming step, both at the end of power-up initialization and for later reprogramming. A client presents one request that carries the wanted burst length, burst type, CAS latency and operating-mode bits for the standard register, a raw word for the extended register, and a two-bit mask saying which of the two registers to write. The block then drives LOAD MODE commands on the command, bank-address and address outputs. It puts a parameterised run of NOP cycles after every load, so the device's minimum load-to-command interval always holds.

A request is refused with a one-cycle error pulse, and no command is issued, if any of these is true: a bank is open, a burst is running, the mask is empty, or the standard register is chosen with a reserved burst-length code. After the last gap the block pulses done. It holds the decoded burst length, burst type and CAS latency of the standard register, and the extended word, for the rest of the controller. These stay valid until the same register is loaded again.

Top module: `mrs_load_seq`

## Requirements
- R1: After reset, mem_cmd is NOP (2'b00), mem_ba and mem_addr are 0, busy, done and error are 0, and cur_bl, cur_bt, cur_cl and cur_ext are 0.
- R2: A standard-register load drives mem_cmd = LOAD (2'b01) with mem_ba = 2'b00. Its mem_addr carries the burst-length code in bits 2:0, the burst type in bit 3 (1 = interleaved), the CAS latency code in bits 6:4 and the operating mode in bits 11:7, with all higher bits 0.
- R3: An extended-register load drives mem_cmd = LOAD with mem_ba = 2'b10 and mem_addr equal to req_ext.
- R4: Each LOAD is followed by exactly TMRD-1 NOP cycles before the next LOAD or the done pulse. TMRD must be at least 2.
- R5: req_sel bit 0 selects the standard register and bit 1 selects the extended register. An accepted request issues its first LOAD in the cycle after acceptance. When both registers are selected and EXT_FIRST = 0, the standard register is loaded first.
- R6: done is high for one cycle, in the cycle after the final NOP of the gap. busy is high from the first LOAD through the last NOP and is low while done is high.
- R7: A request made while bank_active or burst_busy is high raises error for exactly one cycle, in the following cycle. No LOAD is issued and the held fields do not change.
- R8: A request that selects the standard register with a burst-length code other than 001 (2 beats), 010 (4 beats) or 011 (8 beats) is rejected like R7. A request with req_sel = 00 is rejected the same way. The burst-length code is not checked when only the extended register is selected.
- R9: One cycle after a standard LOAD, cur_bl shows the burst length in beats (2, 4 or 8), cur_bt shows the burst type and cur_cl shows the CAS latency code. One cycle after an extended LOAD, cur_ext shows the extended word. Each value holds until its own register is loaded again.
- R10: A request is taken only while busy is low. A request made while busy is high is ignored, and the command sequence in progress continues unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Load request |
| req_sel | input | 2 | Bit 0 standard register, bit 1 extended register |
| req_bl | input | 3 | Burst-length code |
| req_bt | input | 1 | Burst type, 1 = interleaved |
| req_cl | input | 3 | CAS latency code |
| req_opmode | input | 5 | Operating-mode bits |
| req_ext | input | ADDR_W | Extended register word |
| bank_active | input | 1 | Some bank is open |
| burst_busy | input | 1 | A burst is in progress |
| mem_cmd | output | 2 | 00 NOP, 01 LOAD MODE |
| mem_ba | output | 2 | Bank address, 00 standard, 10 extended |
| mem_addr | output | ADDR_W | Address bus carrying the register word |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| error | output | 1 | One-cycle rejection pulse |
| cur_bl | output | 4 | Programmed burst length in beats |
| cur_bt | output | 1 | Programmed burst type |
| cur_cl | output | 3 | Programmed CAS latency code |
| cur_ext | output | ADDR_W | Programmed extended word |

## Verification
A pending mask that clears the wrong bit, or that does not clear at all, shows up as a missing, repeated or swapped LOAD on mem_ba. This appears at most one gap after the first load. A gap counter that loads an off-by-one value moves the second LOAD, or the done pulse, by one cycle. A bad acceptance guard shows up in the very next cycle, either as a LOAD where an error pulse was expected or as an error pulse where a LOAD was expected. Stale or mis-decoded field registers are visible on cur_bl, cur_bt, cur_cl and cur_ext one cycle after the matching LOAD. The bench compares every one of these outputs on every cycle.

// File: rtl/mrs_pkg.sv
package mrs_pkg;

    typedef enum logic [1:0] {
        CMD_NOP = 2'b00,
        CMD_LMR = 2'b01
    } mem_cmd_e;

    typedef enum logic [1:0] {
        SQ_IDLE,
        SQ_LOAD,
        SQ_GAP
    } seq_state_e;

    // packs into the 12-bit standard register word, burst length at the LSBs
    typedef struct packed {
        logic [4:0] op_mode;
        logic [2:0] cas_lat;
        logic       burst_il;
        logic [2:0] bl_code;
    } std_fields_t;

    localparam logic [1:0] BA_STD = 2'b00;
    localparam logic [1:0] BA_EXT = 2'b10;

    function automatic logic bl_legal(input logic [2:0] code);
        return (code == 3'd1) || (code == 3'd2) || (code == 3'd3);
    endfunction

    function automatic logic [3:0] bl_beats(input logic [2:0] code);
        case (code)
            3'd1:    return 4'd2;
            3'd2:    return 4'd4;
            3'd3:    return 4'd8;
            default: return 4'd0;
        endcase
    endfunction

endpackage

// File: rtl/mrs_gap_timer.sv
module mrs_gap_timer #(
    parameter int TMRD = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic last
);
    localparam int CW = $clog2(TMRD + 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (start)
            cnt <= CW'(TMRD - 1);
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign last = (cnt == CW'(1));

endmodule

// File: rtl/mrs_field_store.sv
module mrs_field_store
    import mrs_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_std,
    input  logic              wr_ext,
    input  std_fields_t       std_word,
    input  logic [ADDR_W-1:0] ext_word,
    output logic [3:0]        cur_bl,
    output logic              cur_bt,
    output logic [2:0]        cur_cl,
    output logic [ADDR_W-1:0] cur_ext
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cur_bl  <= '0;
            cur_bt  <= 1'b0;
            cur_cl  <= '0;
            cur_ext <= '0;
        end else begin
            if (wr_std) begin
                cur_bl <= bl_beats(std_word.bl_code);
                cur_bt <= std_word.burst_il;
                cur_cl <= std_word.cas_lat;
            end
            if (wr_ext)
                cur_ext <= ext_word;
        end
    end

endmodule

// File: rtl/mrs_load_seq.sv
module mrs_load_seq
    import mrs_pkg::*;
#(
    parameter int ADDR_W    = 12,
    parameter int TMRD      = 2,
    parameter bit EXT_FIRST = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [1:0]        req_sel,
    input  logic [2:0]        req_bl,
    input  logic              req_bt,
    input  logic [2:0]        req_cl,
    input  logic [4:0]        req_opmode,
    input  logic [ADDR_W-1:0] req_ext,
    input  logic              bank_active,
    input  logic              burst_busy,
    output logic [1:0]        mem_cmd,
    output logic [1:0]        mem_ba,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              busy,
    output logic              done,
    output logic              error,
    output logic [3:0]        cur_bl,
    output logic              cur_bt,
    output logic [2:0]        cur_cl,
    output logic [ADDR_W-1:0] cur_ext
);
    seq_state_e        state;
    logic [1:0]        pend;
    std_fields_t       std_w;
    logic [ADDR_W-1:0] ext_w;
    logic              pick_ext;
    logic              gap_last;
    logic              reject;
    logic              in_load;

    generate
        if (EXT_FIRST) begin : g_ext_first
            assign pick_ext = pend[1];
        end else begin : g_std_first
            assign pick_ext = ~pend[0];
        end
    endgenerate

    assign reject = bank_active || burst_busy || (req_sel == 2'b00) ||
                    (req_sel[0] && !bl_legal(req_bl));
    assign in_load = (state == SQ_LOAD);

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= SQ_IDLE;
            pend  <= '0;
            std_w <= '0;
            ext_w <= '0;
            done  <= 1'b0;
            error <= 1'b0;
        end else begin
            done  <= 1'b0;
            error <= 1'b0;
            case (state)
                SQ_IDLE: begin
                    if (req_valid) begin
                        if (reject) begin
                            error <= 1'b1;
                        end else begin
                            pend  <= req_sel;
                            std_w <= '{op_mode: req_opmode, cas_lat: req_cl,
                                       burst_il: req_bt, bl_code: req_bl};
                            ext_w <= req_ext;
                            state <= SQ_LOAD;
                        end
                    end
                end
                SQ_LOAD: begin
                    pend[pick_ext] <= 1'b0;
                    state          <= SQ_GAP;
                end
                SQ_GAP: begin
                    if (gap_last) begin
                        if (pend != 2'b00) begin
                            state <= SQ_LOAD;
                        end else begin
                            state <= SQ_IDLE;
                            done  <= 1'b1;
                        end
                    end
                end
                default: state <= SQ_IDLE;
            endcase
        end
    end

    mrs_gap_timer #(.TMRD(TMRD)) gap_i (
        .clk   (clk),
        .rst   (rst),
        .start (in_load),
        .last  (gap_last)
    );

    mrs_field_store #(.ADDR_W(ADDR_W)) store_i (
        .clk      (clk),
        .rst      (rst),
        .wr_std   (in_load && !pick_ext),
        .wr_ext   (in_load && pick_ext),
        .std_word (std_w),
        .ext_word (ext_w),
        .cur_bl   (cur_bl),
        .cur_bt   (cur_bt),
        .cur_cl   (cur_cl),
        .cur_ext  (cur_ext)
    );

    always_comb begin
        mem_cmd  = CMD_NOP;
        mem_ba   = BA_STD;
        mem_addr = '0;
        if (in_load) begin
            mem_cmd  = CMD_LMR;
            mem_ba   = pick_ext ? BA_EXT : BA_STD;
            mem_addr = pick_ext ? ext_w : ADDR_W'(std_w);
        end
    end

    assign busy = (state != SQ_IDLE);

endmodule

// File: rtl/mrs_load_seq_chk.sv
module mrs_load_seq_chk
    import mrs_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic              bank_active,
    input logic              burst_busy,
    input logic [1:0]        mem_cmd,
    input logic [1:0]        mem_ba,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              busy,
    input logic              done,
    input logic              error,
    input logic [3:0]        cur_bl
);
    // R2
    std_bl_legal_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_cmd == CMD_LMR && mem_ba == BA_STD) |-> bl_legal(mem_addr[2:0]));

    // R3
    ba_select_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_cmd == CMD_LMR) |-> (mem_ba == BA_STD || mem_ba == BA_EXT));

    // R4
    nop_after_load_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_cmd == CMD_LMR) |=> (mem_cmd == CMD_NOP && busy));

    // R6
    done_idle_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> (!busy && mem_cmd == CMD_NOP && !error));

    // R6
    done_single_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R7
    refuse_active_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !busy && (bank_active || burst_busy)) |=>
            (error && mem_cmd == CMD_NOP && !busy));

    // R7
    error_single_chk: assert property (@(posedge clk) disable iff (rst)
        error |=> !error);

    // R9
    field_decode_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_cmd == CMD_LMR && mem_ba == BA_STD) |=>
            (cur_bl == bl_beats($past(mem_addr[2:0]))));

endmodule

bind mrs_load_seq mrs_load_seq_chk #(.ADDR_W(ADDR_W)) chk_i (
    .clk         (clk),
    .rst         (rst),
    .req_valid   (req_valid),
    .bank_active (bank_active),
    .burst_busy  (burst_busy),
    .mem_cmd     (mem_cmd),
    .mem_ba      (mem_ba),
    .mem_addr    (mem_addr),
    .busy        (busy),
    .done        (done),
    .error       (error),
    .cur_bl      (cur_bl)
);

// File: tb/mrs_load_seq_tb_top.sv
module mrs_load_seq_tb_top;

    localparam int AW   = 12;
    localparam int GAPC = 3;

    typedef struct packed {
        logic          dn;
        logic          er;
        logic          bz;
        logic [1:0]    cmd;
        logic [1:0]    ba;
        logic [AW-1:0] addr;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0;
    logic [1:0]    req_sel = '0;
    logic [2:0]    req_bl = '0;
    logic          req_bt = 1'b0;
    logic [2:0]    req_cl = '0;
    logic [4:0]    req_opmode = '0;
    logic [AW-1:0] req_ext = '0;
    logic          bank_active = 1'b0;
    logic          burst_busy = 1'b0;
    logic [1:0]    mem_cmd;
    logic [1:0]    mem_ba;
    logic [AW-1:0] mem_addr;
    logic          busy, done, error;
    logic [3:0]    cur_bl;
    logic          cur_bt;
    logic [2:0]    cur_cl;
    logic [AW-1:0] cur_ext;

    int     vectors = 0;
    int     fails   = 0;
    string  tag     = "R1";
    exp_t   q[$];
    logic [3:0]    m_bl  = '0;
    logic          m_bt  = 1'b0;
    logic [2:0]    m_cl  = '0;
    logic [AW-1:0] m_ext = '0;

    always #2.5 clk = ~clk;

    mrs_load_seq #(.ADDR_W(AW), .TMRD(GAPC), .EXT_FIRST(1'b0)) dut_i (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_sel(req_sel),
        .req_bl(req_bl), .req_bt(req_bt), .req_cl(req_cl), .req_opmode(req_opmode),
        .req_ext(req_ext), .bank_active(bank_active), .burst_busy(burst_busy),
        .mem_cmd(mem_cmd), .mem_ba(mem_ba), .mem_addr(mem_addr), .busy(busy),
        .done(done), .error(error), .cur_bl(cur_bl), .cur_bt(cur_bt),
        .cur_cl(cur_cl), .cur_ext(cur_ext)
    );

    function automatic logic [3:0] beats(input logic [2:0] c);
        if (c == 3'b001) return 4'd2;
        if (c == 3'b010) return 4'd4;
        if (c == 3'b011) return 4'd8;
        return 4'd0;
    endfunction

    function automatic exp_t mk(input logic dn, input logic er, input logic bz,
                                input logic [1:0] cmd, input logic [1:0] ba,
                                input logic [AW-1:0] addr);
        exp_t e;
        e.dn = dn; e.er = er; e.bz = bz; e.cmd = cmd; e.ba = ba; e.addr = addr;
        return e;
    endfunction

    task automatic push_load(input logic [1:0] ba, input logic [AW-1:0] word);
        q.push_back(mk(1'b0, 1'b0, 1'b1, 2'b01, ba, word));
        for (int i = 0; i < GAPC - 1; i++)
            q.push_back(mk(1'b0, 1'b0, 1'b1, 2'b00, 2'b00, '0));
    endtask

    task automatic step(input logic r, input logic [1:0] s, input logic [2:0] bl,
                        input logic bt, input logic [2:0] cl, input logic [4:0] om,
                        input logic [AW-1:0] ex, input logic act, input logic bb);
        exp_t e;
        logic idle_now;
        logic bad;
        @(negedge clk);
        e = (q.size() > 0) ? q[0] : mk(1'b0, 1'b0, 1'b0, 2'b00, 2'b00, '0);
        vectors++;
        if ({done, error, busy, mem_cmd, mem_ba, mem_addr} !== e ||
            {cur_bl, cur_bt, cur_cl, cur_ext} !== {m_bl, m_bt, m_cl, m_ext}) begin
            fails++;
            $display("FAIL %s t=%0t actual dn=%b er=%b bz=%b cmd=%b ba=%b addr=%h bl=%0d bt=%b cl=%0d ext=%h expected dn=%b er=%b bz=%b cmd=%b ba=%b addr=%h bl=%0d bt=%b cl=%0d ext=%h",
                     tag, $time, done, error, busy, mem_cmd, mem_ba, mem_addr,
                     cur_bl, cur_bt, cur_cl, cur_ext, e.dn, e.er, e.bz, e.cmd,
                     e.ba, e.addr, m_bl, m_bt, m_cl, m_ext);
        end
        idle_now = (q.size() == 0) || e.dn || e.er;
        if (q.size() > 0) begin
            if (e.cmd == 2'b01 && e.ba == 2'b00) begin
                m_bl = beats(e.addr[2:0]);
                m_bt = e.addr[3];
                m_cl = e.addr[6:4];
            end else if (e.cmd == 2'b01 && e.ba == 2'b10) begin
                m_ext = e.addr;
            end
            void'(q.pop_front());
        end
        req_valid = r; req_sel = s; req_bl = bl; req_bt = bt; req_cl = cl;
        req_opmode = om; req_ext = ex; bank_active = act; burst_busy = bb;
        if (r && idle_now) begin
            bad = act || bb || (s == 2'b00) || (s[0] && beats(bl) == 4'd0);
            if (bad) begin
                q.push_back(mk(1'b0, 1'b1, 1'b0, 2'b00, 2'b00, '0));
            end else begin
                if (s[0]) push_load(2'b00, {om, cl, bt, bl});
                if (s[1]) push_load(2'b10, ex);
                q.push_back(mk(1'b1, 1'b0, 1'b0, 2'b00, 2'b00, '0));
            end
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++)
            step(1'b0, 2'b00, 3'b000, 1'b0, 3'b000, 5'd0, '0, 1'b0, 1'b0);
    endtask

    task automatic finish_run();
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired, actual hung expected finished");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1: reset values
        tag = "R1"; idle(2);
        // R2 R3 R4 R5 R6 R9: both registers, BL4 sequential CL3
        tag = "R5";
        step(1'b1, 2'b11, 3'b010, 1'b0, 3'b011, 5'b00000, 12'h020, 1'b0, 1'b0);
        idle(10);
        // R2 R9: standard only, BL8 interleaved CL2, op bits
        tag = "R2";
        step(1'b1, 2'b01, 3'b011, 1'b1, 3'b010, 5'b10101, 12'h000, 1'b0, 1'b0);
        idle(6);
        // R3 R8 R9: extended only, reserved BL ignored, std fields kept
        tag = "R3";
        step(1'b1, 2'b10, 3'b111, 1'b0, 3'b001, 5'd0, 12'hA5C, 1'b0, 1'b0);
        idle(6);
        // R7: bank open
        tag = "R7";
        step(1'b1, 2'b11, 3'b001, 1'b0, 3'b010, 5'd0, 12'h111, 1'b1, 1'b0);
        idle(3);
        // R7: burst running
        step(1'b1, 2'b01, 3'b001, 1'b0, 3'b010, 5'd0, 12'h111, 1'b0, 1'b1);
        idle(3);
        // R8: reserved burst-length codes and empty mask
        tag = "R8";
        step(1'b1, 2'b01, 3'b000, 1'b0, 3'b010, 5'd0, 12'h0, 1'b0, 1'b0);
        idle(2);
        step(1'b1, 2'b11, 3'b100, 1'b1, 3'b010, 5'd0, 12'h3, 1'b0, 1'b0);
        idle(2);
        step(1'b1, 2'b01, 3'b111, 1'b0, 3'b011, 5'd0, 12'h0, 1'b0, 1'b0);
        idle(2);
        step(1'b1, 2'b00, 3'b010, 1'b0, 3'b011, 5'd0, 12'h0, 1'b0, 1'b0);
        idle(2);
        // R10: request held high; changes while busy are ignored
        tag = "R10";
        step(1'b1, 2'b11, 3'b001, 1'b1, 3'b011, 5'b00001, 12'h7E1, 1'b0, 1'b0);
        for (int i = 0; i < 2 * GAPC; i++)
            step(1'b1, 2'b01, 3'b011, 1'b0, 3'b010, 5'b11111, 12'hFFF, 1'b0, 1'b0);
        idle(8);
        // R4 R6: back-to-back requests at the done cycle
        tag = "R6";
        step(1'b1, 2'b10, 3'b000, 1'b0, 3'b000, 5'd0, 12'h0C3, 1'b0, 1'b0);
        idle(GAPC - 1);
        step(1'b0, 2'b00, 3'b000, 1'b0, 3'b000, 5'd0, 12'h0, 1'b0, 1'b0);
        step(1'b1, 2'b01, 3'b001, 1'b0, 3'b001, 5'd0, 12'h0, 1'b0, 1'b0);
        idle(8);
        finish_run();
    end

endmodule